// File: doc/BRIEF.md
# Keyboard Command Sequencer

This block is the control layer that sits between host logic and a pair of PS/2 byte engines, one transmitter and one receiver. Host logic asks for one of four keyboard operations by pulsing a request line: reset, enable scanning, restore defaults, or load the three indicator lamps. The sequencer then sends the command byte, plus the lamp byte for the indicator command, through a valid/ready handshake. It waits for the keyboard's acknowledge after every byte and sends a byte again when the keyboard asks for a resend. After a reset it also waits for the self-test result.

Bytes that arrive while no command is outstanding are key data. They go out on a separate scan stream with a one-cycle strobe. Protocol replies that belong to an exchange never show up there. A buffer-overflow report sets a sticky flag, and software clears that flag. Requests that arrive during an exchange are held and served later in a fixed order. Each exchange ends with either a one-cycle done pulse or a one-cycle error pulse.

Top module: `kbd_cmd_seq`

## Requirements
- R1: After reset, busy_o, done_o, error_o, tx_valid_o, scan_valid_o and overflow_o are all low.
- R2: Command bytes are 0xFF for reset, 0xF4 for enable scanning and 0xF6 for restore defaults. The indicator command sends 0xED and then a lamp byte. That lamp byte carries scroll lock in bit 0, num lock in bit 1 and caps lock in bit 2, taken from leds_i[0], leds_i[1] and leds_i[2] at the moment the command is accepted. Bits 7 to 3 are zero.
- R3: tx_valid_o stays high with tx_data_o unchanged until tx_ready_i is seen. After each accepted byte, nothing more is sent until the keyboard replies 0xFA. A reply that is not 0xFA or 0xFE is ignored while the sequencer waits for an acknowledge.
- R4: A 0xFE reply causes the same byte to be sent again, up to MAX_RESEND (3) times. A 0xFE reply after the last allowed resend ends the exchange with an error.
- R5: Once 0xFF has been acknowledged, the next received byte must be 0xAA. If it is, the exchange completes. Any other byte ends the exchange with an error.
- R6: If no deciding reply arrives within TIMEOUT_CYC cycles of waiting, the exchange ends with an error.
- R7: A received byte other than 0x00 that arrives while busy_o is low appears on scan_data_o, with scan_valid_o high for one cycle in the next cycle. Bytes received while busy_o is high are never forwarded.
- R8: A received 0x00 is never forwarded. It sets overflow_o, which stays high until overflow_clr_i is pulsed.
- R9: Pending requests are served in the order reset, indicators, enable, defaults. A request is remembered until it is served.
- R10: Each exchange ends with exactly one pulse: done_o on success or error_o on failure. The pulse lasts one cycle, and busy_o is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_reset_i | input | 1 | Request keyboard reset |
| req_leds_i | input | 1 | Request indicator update |
| req_enable_i | input | 1 | Request enable scanning |
| req_defaults_i | input | 1 | Request restore defaults |
| leds_i | input | 3 | Lamp states: caps, num, scroll |
| tx_data_o | output | 8 | Byte to transmitter |
| tx_valid_o | output | 1 | Byte offered to transmitter |
| tx_ready_i | input | 1 | Transmitter takes the byte |
| rx_data_i | input | 8 | Byte from receiver |
| rx_valid_i | input | 1 | Received byte strobe |
| scan_data_o | output | 8 | Forwarded key byte |
| scan_valid_o | output | 1 | Forwarded byte strobe |
| overflow_o | output | 1 | Sticky keyboard-overflow flag |
| overflow_clr_i | input | 1 | Clear overflow flag |
| busy_o | output | 1 | Exchange in progress |
| done_o | output | 1 | Exchange succeeded (pulse) |
| error_o | output | 1 | Exchange failed (pulse) |

## Verification
Some properties are checked by assertions on every cycle. These cover the transmit hold while ready is low, the quiet transmit side while an acknowledge is awaited, the bound on the resend counter, the mutual exclusion of done and error, the absence of scan strobes after bytes received while busy, and the persistence of the overflow flag and of pending requests. Other behaviour can only be shown by the bench's scenarios: the exact byte sequence of each command, the lamp byte layout, the service order of stacked requests, the resend limit, the self-test check after reset, and the timeout.

// File: rtl/kbd_seq_pkg.sv
package kbd_seq_pkg;

  localparam int N_CMD = 4;

  // index doubles as priority: lower wins
  typedef enum logic [1:0] {
    CMD_RESET    = 2'd0,
    CMD_LEDS     = 2'd1,
    CMD_ENABLE   = 2'd2,
    CMD_DEFAULTS = 2'd3
  } kbd_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT_ACK,
    ST_WAIT_BAT
  } seq_state_e;

  typedef enum logic [2:0] {
    RX_ACK,
    RX_RESEND,
    RX_BAT,
    RX_OVF,
    RX_OTHER
  } rx_class_e;

  localparam logic [7:0] KB_ACK    = 8'hFA;
  localparam logic [7:0] KB_RESEND = 8'hFE;
  localparam logic [7:0] KB_BAT_OK = 8'hAA;
  localparam logic [7:0] KB_OVF    = 8'h00;

  function automatic logic [7:0] cmd_opcode(kbd_cmd_e c);
    case (c)
      CMD_RESET:  return 8'hFF;
      CMD_LEDS:   return 8'hED;
      CMD_ENABLE: return 8'hF4;
      default:    return 8'hF6;
    endcase
  endfunction

endpackage

// File: rtl/kbd_rx_class.sv
module kbd_rx_class
  import kbd_seq_pkg::*;
(
  input  logic [7:0] data_i,
  output rx_class_e  class_o
);

  always_comb begin
    case (data_i)
      KB_ACK:    class_o = RX_ACK;
      KB_RESEND: class_o = RX_RESEND;
      KB_BAT_OK: class_o = RX_BAT;
      KB_OVF:    class_o = RX_OVF;
      default:   class_o = RX_OTHER;
    endcase
  end

endmodule

// File: rtl/kbd_req_arb.sv
module kbd_req_arb #(
  parameter int N = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         req_i,
  input  logic                 take_i,
  output logic                 any_o,
  output logic [$clog2(N)-1:0] gnt_idx_o
);

  localparam int IW = $clog2(N);

  logic [N-1:0] pend_q;
  logic [N-1:0] gnt_oh;

  always_comb begin
    gnt_oh    = '0;
    gnt_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        gnt_oh    = '0;
        gnt_oh[i] = 1'b1;
        gnt_idx_o = IW'(i);
      end
    end
  end

  assign any_o = |pend_q;

  for (genvar g = 0; g < N; g++) begin : g_pend
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[g] <= 1'b0;
      else         pend_q[g] <= (pend_q[g] & ~(take_i & gnt_oh[g])) | req_i[g];
    end

    // R9: a request stays pending until it is granted
    assert_pend_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q[g] && !(take_i && gnt_oh[g])) |=> pend_q[g]);
  end

endmodule

// File: rtl/kbd_wait_timer.sv
module kbd_wait_timer #(
  parameter int LIMIT = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic expired_o
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || restart_i) cnt_q <= '0;
    else if (!expired_o)          cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(LIMIT));

endmodule

// File: rtl/kbd_cmd_seq.sv
module kbd_cmd_seq
  import kbd_seq_pkg::*;
#(
  parameter int TIMEOUT_CYC = 50000,
  parameter int MAX_RESEND  = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_reset_i,
  input  logic       req_leds_i,
  input  logic       req_enable_i,
  input  logic       req_defaults_i,
  input  logic [2:0] leds_i,
  output logic [7:0] tx_data_o,
  output logic       tx_valid_o,
  input  logic       tx_ready_i,
  input  logic [7:0] rx_data_i,
  input  logic       rx_valid_i,
  output logic [7:0] scan_data_o,
  output logic       scan_valid_o,
  output logic       overflow_o,
  input  logic       overflow_clr_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       error_o
);

  localparam int RW = $clog2(MAX_RESEND + 1);
  localparam int IW = $clog2(N_CMD);

  seq_state_e    state_q, state_d;
  kbd_cmd_e      cmd_q, cmd_d;
  logic          idx_q, idx_d;
  logic [RW-1:0] retry_q, retry_d;
  logic [2:0]    leds_q, leds_d;
  logic          done_d, err_d;
  logic          done_q, err_q;
  logic          ovf_q;
  logic [7:0]    scan_q;
  logic          scan_v_q;

  logic          any_req;
  logic [IW-1:0] gnt_idx;
  logic          take;
  rx_class_e     rx_cls;
  logic          waiting;
  logic          tmo;

  kbd_req_arb #(.N(N_CMD)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     ({req_defaults_i, req_enable_i, req_leds_i, req_reset_i}),
    .take_i    (take),
    .any_o     (any_req),
    .gnt_idx_o (gnt_idx)
  );

  kbd_rx_class u_cls (
    .data_i  (rx_data_i),
    .class_o (rx_cls)
  );

  assign waiting = (state_q == ST_WAIT_ACK) || (state_q == ST_WAIT_BAT);

  kbd_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (waiting),
    .restart_i (state_d != state_q),
    .expired_o (tmo)
  );

  assign take       = (state_q == ST_IDLE) && any_req;
  assign tx_valid_o = (state_q == ST_SEND);
  assign tx_data_o  = idx_q ? {5'b0, leds_q} : cmd_opcode(cmd_q);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign error_o    = err_q;
  assign overflow_o = ovf_q;
  assign scan_data_o  = scan_q;
  assign scan_valid_o = scan_v_q;

  always_comb begin
    state_d = state_q;
    cmd_d   = cmd_q;
    idx_d   = idx_q;
    retry_d = retry_q;
    leds_d  = leds_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (any_req) begin
          cmd_d   = kbd_cmd_e'(gnt_idx);
          idx_d   = 1'b0;
          retry_d = '0;
          if (kbd_cmd_e'(gnt_idx) == CMD_LEDS) leds_d = leds_i;
          state_d = ST_SEND;
        end
      end
      ST_SEND: begin
        if (tx_ready_i) state_d = ST_WAIT_ACK;
      end
      ST_WAIT_ACK: begin
        if (rx_valid_i && rx_cls == RX_ACK) begin
          if (cmd_q == CMD_LEDS && !idx_q) begin
            idx_d   = 1'b1;
            retry_d = '0;
            state_d = ST_SEND;
          end else if (cmd_q == CMD_RESET) begin
            state_d = ST_WAIT_BAT;
          end else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end else if (rx_valid_i && rx_cls == RX_RESEND) begin
          if (retry_q == RW'(MAX_RESEND)) begin
            state_d = ST_IDLE;
            err_d   = 1'b1;
          end else begin
            retry_d = retry_q + 1'b1;
            state_d = ST_SEND;
          end
        end else if (tmo) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end
      end
      ST_WAIT_BAT: begin
        if (rx_valid_i) begin
          state_d = ST_IDLE;
          if (rx_cls == RX_BAT) done_d = 1'b1;
          else                  err_d  = 1'b1;
        end else if (tmo) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= CMD_RESET;
      idx_q   <= 1'b0;
      retry_q <= '0;
      leds_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      idx_q   <= idx_d;
      retry_q <= retry_d;
      leds_q  <= leds_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  // key-data stream and overflow flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q    <= 1'b0;
      scan_q   <= '0;
      scan_v_q <= 1'b0;
    end else begin
      ovf_q    <= (ovf_q & ~overflow_clr_i) | (rx_valid_i && rx_cls == RX_OVF);
      scan_v_q <= rx_valid_i && (state_q == ST_IDLE) && (rx_cls != RX_OVF);
      if (rx_valid_i) scan_q <= rx_data_i;
    end
  end

  assert_tx_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  assert_ack_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_ACK && !rx_valid_i) |=> !tx_valid_o);

  assert_retry_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_q <= RW'(MAX_RESEND));

  assert_scan_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rx_valid_i) |=> !scan_valid_o);

  assert_no_zero_scan_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_valid_o |-> (scan_data_o != 8'h00));

  assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !overflow_clr_i) |=> overflow_o);

  assert_done_err_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && error_o));

  assert_end_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || error_o) |-> (!busy_o && $past(busy_o)));

endmodule

// File: tb/sim_kbd_cmd_seq.sv
module sim_kbd_cmd_seq;

  localparam int TMO = 40;

  typedef struct packed {
    logic [1:0]       cmd;   // 0 reset, 1 leds, 2 enable, 3 defaults
    logic [2:0]       leds;
    logic [2:0]       n;
    logic [5:0][16:0] st;    // {expect_tx, tx_byte, reply}
    logic             ok;
  } vec_t;

  function automatic logic [16:0] s(input logic h, input logic [7:0] t, input logic [7:0] r);
    return {h, t, r};
  endfunction

  localparam logic [16:0] Z = 17'h0;

  localparam vec_t VEC [10] = '{
    '{cmd:2'd2, leds:3'd0, n:3'd1, st:{Z,Z,Z,Z,Z,s(1'b1,8'hF4,8'hFA)}, ok:1'b1},                 // R2 enable
    '{cmd:2'd3, leds:3'd0, n:3'd1, st:{Z,Z,Z,Z,Z,s(1'b1,8'hF6,8'hFA)}, ok:1'b1},                 // R2 defaults
    '{cmd:2'd1, leds:3'd5, n:3'd2, st:{Z,Z,Z,Z,s(1'b1,8'h05,8'hFA),s(1'b1,8'hED,8'hFA)}, ok:1'b1}, // R2 leds
    '{cmd:2'd0, leds:3'd0, n:3'd2, st:{Z,Z,Z,Z,s(1'b0,8'h00,8'hAA),s(1'b1,8'hFF,8'hFA)}, ok:1'b1}, // R5 good
    '{cmd:2'd0, leds:3'd0, n:3'd2, st:{Z,Z,Z,Z,s(1'b0,8'h00,8'h55),s(1'b1,8'hFF,8'hFA)}, ok:1'b0}, // R5 bad
    '{cmd:2'd2, leds:3'd0, n:3'd2, st:{Z,Z,Z,Z,s(1'b1,8'hF4,8'hFA),s(1'b1,8'hF4,8'hFE)}, ok:1'b1}, // R4 one
    '{cmd:2'd1, leds:3'd2, n:3'd3, st:{Z,Z,Z,s(1'b1,8'h02,8'hFA),s(1'b1,8'h02,8'hFE),s(1'b1,8'hED,8'hFA)}, ok:1'b1}, // R4 2nd byte
    '{cmd:2'd2, leds:3'd0, n:3'd4, st:{Z,Z,s(1'b1,8'hF4,8'hFE),s(1'b1,8'hF4,8'hFE),s(1'b1,8'hF4,8'hFE),s(1'b1,8'hF4,8'hFE)}, ok:1'b0}, // R4 limit
    '{cmd:2'd2, leds:3'd0, n:3'd4, st:{Z,Z,s(1'b1,8'hF4,8'hFA),s(1'b1,8'hF4,8'hFE),s(1'b1,8'hF4,8'hFE),s(1'b1,8'hF4,8'hFE)}, ok:1'b1}, // R4 edge
    '{cmd:2'd2, leds:3'd0, n:3'd2, st:{Z,Z,Z,Z,s(1'b0,8'h00,8'hFA),s(1'b1,8'hF4,8'h1C)}, ok:1'b1}  // R3 ignored
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic [2:0] leds = '0;
  logic       tx_ready = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_valid = 1'b0;
  logic       ovf_clr = 1'b0;
  logic [7:0] tx_data, scan_data;
  logic       tx_valid, scan_valid, ovf, busy, done, err;

  int checks = 0;
  int failures = 0;
  int done_seen = 0;
  int err_seen = 0;
  int scan_seen = 0;
  logic [7:0] last_scan = '0;
  int cyc = 0;

  always #10 clk = ~clk;

  kbd_cmd_seq #(.TIMEOUT_CYC(TMO), .MAX_RESEND(3)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_reset_i(req[0]), .req_leds_i(req[1]), .req_enable_i(req[2]), .req_defaults_i(req[3]),
    .leds_i(leds),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .rx_data_i(rx_data), .rx_valid_i(rx_valid),
    .scan_data_o(scan_data), .scan_valid_o(scan_valid),
    .overflow_o(ovf), .overflow_clr_i(ovf_clr),
    .busy_o(busy), .done_o(done), .error_o(err)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (done) done_seen <= done_seen + 1;
    if (err)  err_seen  <= err_seen + 1;
    if (scan_valid) begin
      scan_seen <= scan_seen + 1;
      last_scan <= scan_data;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic accept_tx(input logic [7:0] exp, input int stall, input string tag);
    int n = 0;
    logic [7:0] seen;
    while (!tx_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    check({tag, " tx_valid"}, int'(tx_valid), 1);
    check({tag, " tx_data"}, int'(tx_data), int'(exp));
    seen = tx_data;
    for (int i = 0; i < stall; i++) @(negedge clk);
    if (stall > 0) begin
      check("R3 hold valid", int'(tx_valid), 1);
      check("R3 hold data", int'(tx_data), int'(seen));
    end
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] b);
    rx_data  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pulse_req(input logic [3:0] r, input logic [2:0] l);
    leds = l;
    req  = r;
    @(negedge clk);
    req  = '0;
  endtask

  task automatic run_vec(input vec_t v, input int k);
    int d0 = done_seen;
    int e0 = err_seen;
    pulse_req(4'b0001 << v.cmd, v.leds);
    for (int i = 0; i < int'(v.n); i++) begin
      if (v.st[i][16]) accept_tx(v.st[i][15:8], 0, $sformatf("R2 vec%0d step%0d", k, i));
      send_rx(v.st[i][7:0]);
    end
    repeat (4) @(negedge clk);
    check($sformatf("R10 vec%0d done", k), done_seen - d0, v.ok ? 1 : 0);
    check($sformatf("R10 vec%0d error", k), err_seen - e0, v.ok ? 0 : 1);
    check($sformatf("R10 vec%0d idle", k), int'(busy), 0);
  endtask

  initial begin
    while (cyc < 150000) @(negedge clk);
    failures++;
    $display("FAIL R10 watchdog act=hang exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int sc0, d0, e0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 tx_valid", int'(tx_valid), 0);
    check("R1 done", int'(done), 0);
    check("R1 error", int'(err), 0);
    check("R1 scan_valid", int'(scan_valid), 0);
    check("R1 overflow", int'(ovf), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7 idle forwarding
    sc0 = scan_seen;
    send_rx(8'h1C);
    @(negedge clk);
    check("R7 scan count", scan_seen - sc0, 1);
    check("R7 scan data", int'(last_scan), 8'h1C);

    // R8 overflow report
    sc0 = scan_seen;
    send_rx(8'h00);
    @(negedge clk);
    check("R8 not forwarded", scan_seen - sc0, 0);
    check("R8 flag set", int'(ovf), 1);
    repeat (3) @(negedge clk);
    check("R8 flag sticky", int'(ovf), 1);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    check("R8 flag cleared", int'(ovf), 0);

    // table; every reply arrives while busy, so none may reach the scan stream (R7)
    sc0 = scan_seen;
    for (int k = 0; k < 10; k++) run_vec(VEC[k], k);
    check("R7 quiet while busy", scan_seen - sc0, 0);

    // R6 timeout
    e0 = err_seen;
    pulse_req(4'b0100, 3'd0);
    accept_tx(8'hF4, 0, "R6 tx");
    repeat (TMO - 5) @(negedge clk);
    check("R6 not yet", err_seen - e0, 0);
    repeat (15) @(negedge clk);
    check("R6 timeout error", err_seen - e0, 1);
    check("R6 idle", int'(busy), 0);

    // R9 priority with all requests stacked, plus R3 stall
    d0 = done_seen;
    pulse_req(4'b1111, 3'b011);
    accept_tx(8'hFF, 3, "R9 first reset");
    check("R9 busy", int'(busy), 1);
    send_rx(8'hFA);
    send_rx(8'hAA);
    accept_tx(8'hED, 0, "R9 second leds");
    send_rx(8'hFA);
    accept_tx(8'h03, 2, "R9 leds byte R2");
    send_rx(8'hFA);
    accept_tx(8'hF4, 0, "R9 third enable");
    send_rx(8'hFA);
    accept_tx(8'hF6, 0, "R9 fourth defaults");
    send_rx(8'hFA);
    repeat (4) @(negedge clk);
    check("R9 all done", done_seen - d0, 4);
    check("R9 idle", int'(busy), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule